// File: doc/BRIEF.md
# RGB Capture Window with Sync Detection

This block is the first stage of a flat-panel display controller. Pixels sampled by external converters arrive as 24-bit RGB words, either one per clock or two side by side on a 48-bit bus. The block counts pixel positions from the active edge of horizontal sync and line positions from the active edge of vertical sync, keeps only the pixels that fall inside a programmed rectangle, and presents them with a valid strobe. The rectangle's left edge, top edge and height step by one. Its width steps only by two pixels, so the width register holds half the width.

Each sync input is watched on its own. A sync counts as present while edges keep arriving within a programmed number of clocks. Its polarity is found by comparing how long it stays high with how long it stays low, and the shorter level is taken as the pulse. All position counting follows the detected polarity, so either sync polarity yields the same window. The block also drives two timing strobes for the analog front end: a clamp strobe placed by clock position within each line and a gain-calibration strobe placed by line number within each frame.

Configuration is written through a simple address/data write port.

Top module: `rgb_capture_front`

## Requirements
- R1: When mode register bit 0 is 0, each clock carries one pixel on bits 23:0 of `pix_in`, and an accepted pixel appears on bits 23:0 of `pix_data_o` with bits 47:24 forced to zero. When bit 0 is 1, each clock carries two pixels, the earlier one on bits 23:0, and an output word carries two pixels in the same order.
- R2: The input clock on which a horizontal sync active edge arrives is clock index 0 of the line. In single mode pixel number equals clock index. In dual mode clock index c carries pixels 2c and 2c+1. The first accepted pixel is pixel number `h_off`. Outputs appear two clocks after the pixel is presented.
- R3: The line holding the vertical sync active edge is line 0, and each later horizontal sync active edge advances the line number by one. The first accepted line is `v_off`.
- R4: Exactly `v_size` lines, `v_off` through `v_off+v_size-1`, are accepted. Lines beyond the end of the incoming frame yield nothing.
- R5: The accepted width is twice the `h_half` register: pixels `h_off` through `h_off+2*h_half-1`. In dual mode that is `h_half` output words per line.
- R6: In dual mode with an odd `h_off`, every output word is realigned to begin on an odd pixel. Its low half holds pixel 2c-1 and its high half holds pixel 2c, so the first word holds pixels `h_off` and `h_off+1`.
- R7: Each sync's present flag is set by any edge on that sync. It drops once the sync has been idle for more clocks than its timeout register, a little over the timeout value.
- R8: Each sync's active-low flag is 1 when the last measured low run was shorter than the last measured high run. Until both runs have been measured, the flag is 0 and the rising edge counts as active.
- R9: `clamp_o` is high for the clock indices in [`clamp_pos`, `clamp_pos+clamp_len`), with the same two-clock latency as pixels.
- R10: `gain_o` is high for the line numbers in [`gain_line`, `gain_line+gain_len`), with the same latency.
- R11: While reset is held, and after it until the first sync edges, `pix_valid_o`, `pix_data_o`, `clamp_o`, `gain_o`, both present flags and both polarity flags are 0. Whenever `pix_valid_o` is 0, `pix_data_o` is zero.
- R12: Register addresses are: 0 mode, 1 h_off, 2 v_off, 3 h_half, 4 v_size, 5 horizontal timeout, 6 vertical timeout, 7 clamp_pos, 8 clamp_len, 9 gain_line, 10 gain_len. All reset to 0. A write takes effect on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| pix_in | input | 48 | One or two sampled RGB pixels |
| hsync_in | input | 1 | Horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| pix_valid_o | output | 1 | Output word lies inside the window |
| pix_data_o | output | 48 | Windowed pixel word |
| clamp_o | output | 1 | Clamp strobe for the converters |
| gain_o | output | 1 | Gain-calibration strobe for the converters |
| hs_present_o | output | 1 | Horizontal sync is active |
| hs_active_low_o | output | 1 | Horizontal sync pulse is low |
| vs_present_o | output | 1 | Vertical sync is active |
| vs_active_low_o | output | 1 | Vertical sync pulse is low |

## Verification
Two events can land on the same clock. The first is a vertical sync active edge arriving together with a horizontal sync active edge: the line counter must restart at 0 rather than advance. The second is the clamp strobe overlapping the first accepted pixel of a line. The generated frames always start both syncs on the same clock, in both polarities, and one window is placed so its left edge falls inside the clamp span. The outputs are compared every clock against a cycle-aligned model, so a line off by one or a strobe shifted by one clock shows up as data, clamp or gain mismatches.

// File: rtl/rgbcap_pkg.sv
package rgbcap_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE   = 4'd0,
    A_HOFF   = 4'd1,
    A_VOFF   = 4'd2,
    A_HHALF  = 4'd3,
    A_VSIZE  = 4'd4,
    A_HSTMO  = 4'd5,
    A_VSTMO  = 4'd6,
    A_CPOS   = 4'd7,
    A_CLEN   = 4'd8,
    A_GLINE  = 4'd9,
    A_GLEN   = 4'd10
  } reg_addr_e;

  typedef struct packed {
    logic             dual;
    logic [REG_W-1:0] h_off;
    logic [REG_W-1:0] v_off;
    logic [REG_W-1:0] h_half;
    logic [REG_W-1:0] v_size;
    logic [REG_W-1:0] hs_tmo;
    logic [REG_W-1:0] vs_tmo;
    logic [REG_W-1:0] clamp_pos;
    logic [REG_W-1:0] clamp_len;
    logic [REG_W-1:0] gain_line;
    logic [REG_W-1:0] gain_len;
  } cfg_t;
endpackage

// File: rtl/rgbcap_regs.sv
module rgbcap_regs
  import rgbcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output cfg_t              cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_MODE:  cfg_o.dual      <= wdata[0];
        A_HOFF:  cfg_o.h_off     <= wdata;
        A_VOFF:  cfg_o.v_off     <= wdata;
        A_HHALF: cfg_o.h_half    <= wdata;
        A_VSIZE: cfg_o.v_size    <= wdata;
        A_HSTMO: cfg_o.hs_tmo    <= wdata;
        A_VSTMO: cfg_o.vs_tmo    <= wdata;
        A_CPOS:  cfg_o.clamp_pos <= wdata;
        A_CLEN:  cfg_o.clamp_len <= wdata;
        A_GLINE: cfg_o.gain_line <= wdata;
        A_GLEN:  cfg_o.gain_len  <= wdata;
        default: ;
      endcase
    end
  end

  // R12: a write lands in the addressed field on the next edge
  a_r12_hoff_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_HOFF) |=> cfg_o.h_off == $past(wdata));
endmodule

// File: rtl/rgbcap_sync_mon.sv
module rgbcap_sync_mon #(
  parameter int TMO_W = 16,
  parameter int RUN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             act_edge_o,
  output logic             present_o,
  output logic             active_low_o
);
  logic             s_q, s_qq;
  logic [RUN_W-1:0] run_cnt, hi_len, lo_len;
  logic             have_hi, have_lo;
  logic [TMO_W-1:0] idle_cnt;
  logic             rise, fall;

  assign rise       = s_q & ~s_qq;
  assign fall       = ~s_q & s_qq;
  assign act_edge_o = active_low_o ? fall : rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q          <= 1'b0;
      s_qq         <= 1'b0;
      run_cnt      <= '0;
      hi_len       <= '0;
      lo_len       <= '0;
      have_hi      <= 1'b0;
      have_lo      <= 1'b0;
      idle_cnt     <= '0;
      present_o    <= 1'b0;
      active_low_o <= 1'b0;
    end else begin
      s_q  <= sync_i;
      s_qq <= s_q;
      if (rise || fall)        run_cnt <= RUN_W'(1);
      else if (run_cnt != '1)  run_cnt <= run_cnt + 1'b1;
      if (fall) begin
        hi_len  <= run_cnt;
        have_hi <= 1'b1;
      end
      if (rise) begin
        lo_len  <= run_cnt;
        have_lo <= 1'b1;
      end
      if (have_hi && have_lo) active_low_o <= (lo_len < hi_len);
      if (rise || fall) begin
        idle_cnt  <= '0;
        present_o <= 1'b1;
      end else if (idle_cnt >= timeout_i) begin
        present_o <= 1'b0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R7: any edge makes the sync present on the next clock
  a_r7_edge_sets_present: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |=> present_o);
  // R7: idle past the timeout clears presence
  a_r7_timeout_clears: assert property (@(posedge clk) disable iff (rst)
    (!rise && !fall && idle_cnt >= timeout_i) |=> !present_o);
  // R8: polarity can only be low once both runs are measured
  a_r8_needs_both_runs: assert property (@(posedge clk) disable iff (rst)
    active_low_o |-> (have_hi && have_lo));
  // R8: polarity does not move while the measurements hold still
  a_r8_polarity_steady: assert property (@(posedge clk) disable iff (rst)
    ($stable(hi_len) && $stable(lo_len) && $stable(have_hi) && $stable(have_lo))
      |=> $stable(active_low_o));
endmodule

// File: rtl/rgbcap_window.sv
module rgbcap_window
  import rgbcap_pkg::*;
#(
  parameter int PIX_BITS = 24,
  parameter int H_W      = 12,
  parameter int V_W      = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*PIX_BITS-1:0] pix_i,
  input  logic                  hs_edge_i,
  input  logic                  vs_edge_i,
  input  logic                  dual_i,
  input  logic [REG_W-1:0]      h_off_i,
  input  logic [REG_W-1:0]      v_off_i,
  input  logic [REG_W-1:0]      h_half_i,
  input  logic [REG_W-1:0]      v_size_i,
  input  logic [REG_W-1:0]      clamp_pos_i,
  input  logic [REG_W-1:0]      clamp_len_i,
  input  logic [REG_W-1:0]      gain_line_i,
  input  logic [REG_W-1:0]      gain_len_i,
  output logic                  valid_o,
  output logic [2*PIX_BITS-1:0] data_o,
  output logic                  clamp_o,
  output logic                  gain_o
);
  localparam int CMP_W  = REG_W + 2;
  localparam int WORD_W = 2 * PIX_BITS;

  logic [WORD_W-1:0]   pix_q;
  logic [PIX_BITS-1:0] prev_hi;
  logic [H_W-1:0]      h_cnt, h_idx;
  logic [V_W-1:0]      v_cnt, v_idx;
  logic                odd_adj, in_h, in_v, in_clamp, in_gain;
  logic [CMP_W-1:0]    pos, h_lo, h_hi, line, v_hi, c_hi, g_hi;
  logic [WORD_W-1:0]   word;

  always_comb begin
    if (hs_edge_i)          h_idx = '0;
    else if (h_cnt == '1)   h_idx = h_cnt;
    else                    h_idx = h_cnt + 1'b1;

    if (vs_edge_i)                  v_idx = '0;
    else if (hs_edge_i && v_cnt != '1) v_idx = v_cnt + 1'b1;
    else                            v_idx = v_cnt;
  end

  always_comb begin
    odd_adj  = dual_i & h_off_i[0];
    pos      = dual_i ? CMP_W'({h_idx, 1'b0}) : CMP_W'(h_idx);
    h_lo     = CMP_W'(h_off_i) + CMP_W'(odd_adj);
    h_hi     = CMP_W'(h_off_i) + CMP_W'({h_half_i, 1'b0}) + CMP_W'(odd_adj);
    in_h     = (pos >= h_lo) && (pos < h_hi);
    line     = CMP_W'(v_idx);
    v_hi     = CMP_W'(v_off_i) + CMP_W'(v_size_i);
    in_v     = (line >= CMP_W'(v_off_i)) && (line < v_hi);
    c_hi     = CMP_W'(clamp_pos_i) + CMP_W'(clamp_len_i);
    in_clamp = (CMP_W'(h_idx) >= CMP_W'(clamp_pos_i)) && (CMP_W'(h_idx) < c_hi);
    g_hi     = CMP_W'(gain_line_i) + CMP_W'(gain_len_i);
    in_gain  = (line >= CMP_W'(gain_line_i)) && (line < g_hi);
  end

  always_comb begin
    if (!dual_i)         word = {{PIX_BITS{1'b0}}, pix_q[PIX_BITS-1:0]};
    else if (odd_adj)    word = {pix_q[PIX_BITS-1:0], prev_hi};
    else                 word = pix_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q   <= '0;
      prev_hi <= '0;
      h_cnt   <= '1;
      v_cnt   <= '1;
      valid_o <= 1'b0;
      data_o  <= '0;
      clamp_o <= 1'b0;
      gain_o  <= 1'b0;
    end else begin
      pix_q   <= pix_i;
      prev_hi <= pix_q[WORD_W-1:PIX_BITS];
      h_cnt   <= h_idx;
      v_cnt   <= v_idx;
      valid_o <= in_h && in_v;
      data_o  <= (in_h && in_v) ? word : '0;
      clamp_o <= in_clamp;
      gain_o  <= in_gain;
    end
  end

  // R2: horizontal active edge restarts the clock index
  a_r2_h_restart: assert property (@(posedge clk) disable iff (rst)
    hs_edge_i |=> (h_cnt == '0));
  // R3: vertical active edge restarts the line number, even with a horizontal edge
  a_r3_v_restart: assert property (@(posedge clk) disable iff (rst)
    vs_edge_i |=> (v_cnt == '0));
  // R1: single mode leaves the upper half empty
  a_r1_single_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !$past(dual_i)) |-> (data_o[WORD_W-1:PIX_BITS] == '0));
  // R11: no data outside the window
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (data_o == '0));
  // R9: a zero-length clamp never fires
  a_r9_clamp_len: assert property (@(posedge clk) disable iff (rst)
    clamp_o |-> ($past(clamp_len_i) != '0));
  // R10: a zero-length gain span never fires
  a_r10_gain_len: assert property (@(posedge clk) disable iff (rst)
    gain_o |-> ($past(gain_len_i) != '0));
endmodule

// File: rtl/rgb_capture_front.sv
module rgb_capture_front
  import rgbcap_pkg::*;
#(
  parameter int PIX_BITS = 24,
  parameter int H_W      = 12,
  parameter int V_W      = 11,
  parameter int RUN_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic [2*PIX_BITS-1:0] pix_in,
  input  logic                  hsync_in,
  input  logic                  vsync_in,
  output logic                  pix_valid_o,
  output logic [2*PIX_BITS-1:0] pix_data_o,
  output logic                  clamp_o,
  output logic                  gain_o,
  output logic                  hs_present_o,
  output logic                  hs_active_low_o,
  output logic                  vs_present_o,
  output logic                  vs_active_low_o
);
  localparam int N_SYNC = 2;

  cfg_t                cfg;
  logic [N_SYNC-1:0]   sync_raw, act_edge, present, act_low;
  logic [REG_W-1:0]    tmo [N_SYNC];

  assign sync_raw = {vsync_in, hsync_in};
  assign tmo[0]   = cfg.hs_tmo;
  assign tmo[1]   = cfg.vs_tmo;

  rgbcap_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .cfg_o (cfg)
  );

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    rgbcap_sync_mon #(.TMO_W(REG_W), .RUN_W(RUN_W)) u_mon (
      .clk          (clk),
      .rst          (rst),
      .sync_i       (sync_raw[i]),
      .timeout_i    (tmo[i]),
      .act_edge_o   (act_edge[i]),
      .present_o    (present[i]),
      .active_low_o (act_low[i])
    );
  end

  rgbcap_window #(.PIX_BITS(PIX_BITS), .H_W(H_W), .V_W(V_W)) u_win (
    .clk         (clk),
    .rst         (rst),
    .pix_i       (pix_in),
    .hs_edge_i   (act_edge[0]),
    .vs_edge_i   (act_edge[1]),
    .dual_i      (cfg.dual),
    .h_off_i     (cfg.h_off),
    .v_off_i     (cfg.v_off),
    .h_half_i    (cfg.h_half),
    .v_size_i    (cfg.v_size),
    .clamp_pos_i (cfg.clamp_pos),
    .clamp_len_i (cfg.clamp_len),
    .gain_line_i (cfg.gain_line),
    .gain_len_i  (cfg.gain_len),
    .valid_o     (pix_valid_o),
    .data_o      (pix_data_o),
    .clamp_o     (clamp_o),
    .gain_o      (gain_o)
  );

  assign hs_present_o    = present[0];
  assign vs_present_o    = present[1];
  assign hs_active_low_o = act_low[0];
  assign vs_active_low_o = act_low[1];

  // R11: no window output before any horizontal sync has been seen
  a_r11_quiet_without_hsync: assert property (@(posedge clk) disable iff (rst)
    (!hs_present_o && !$past(hs_present_o)) |-> !$rose(pix_valid_o));
endmodule

// File: tb/test_rgb_capture_front.sv
`timescale 1ns/1ps
module test_rgb_capture_front;
  localparam int LINE_CLKS = 40;
  localparam int LINES     = 12;
  localparam int HS_LEN    = 4;
  localparam int VS_LINES  = 2;
  localparam int CLAMP_POS = 5;
  localparam int CLAMP_LEN = 3;
  localparam int GAIN_LINE = 1;
  localparam int GAIN_LEN  = 2;
  localparam int NV        = 5;
  // columns: dual, inverted polarity, h_off, v_off, h_half, v_size, expected word count
  localparam int VEC [NV][7] = '{
    '{0, 0, 5, 2, 4, 3, 24},
    '{0, 0, 0, 0, 20, 12, 480},
    '{1, 1, 6, 1, 5, 4, 20},
    '{1, 1, 7, 3, 3, 2, 6},
    '{1, 0, 1, 11, 39, 5, 39}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [47:0] pix_in;
  logic        hsync_in, vsync_in;
  logic        pix_valid_o, clamp_o, gain_o;
  logic [47:0] pix_data_o;
  logic        hs_present_o, hs_active_low_o, vs_present_o, vs_active_low_o;

  always #2.5 clk = ~clk;

  rgb_capture_front i_rgb_capture_front (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pix_in(pix_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .clamp_o(clamp_o), .gain_o(gain_o),
    .hs_present_o(hs_present_o), .hs_active_low_o(hs_active_low_o),
    .vs_present_o(vs_present_o), .vs_active_low_o(vs_active_low_o)
  );

  typedef struct packed {
    logic        chk;
    logic        v;
    logic [47:0] d;
    logic        c;
    logic        g;
  } exp_t;

  int checks = 0, fails = 0;
  int cur_dual, cur_pol, cur_hoff, cur_voff, cur_hhalf, cur_vsize;
  bit chk_on;
  exp_t pipe0, pipe1;
  int dat_err, clp_err, gn_err, vcount;
  longint bad_act, bad_exp;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] enc(input int l, input int p);
    logic [7:0]  lb = l[7:0];
    logic [15:0] pb = p[15:0];
    return {lb, pb};
  endfunction

  function automatic exp_t model(input int l, input int c);
    exp_t e;
    int   w = 2 * cur_hhalf;
    int   s;
    e = '0;
    e.chk = chk_on;
    if (cur_dual == 0) begin
      s = c;
      e.d = {24'h0, enc(l, c)};
    end else if (cur_hoff % 2 == 0) begin
      s = 2 * c;
      e.d = {enc(l, 2*c+1), enc(l, 2*c)};
    end else begin
      s = 2 * c - 1;
      e.d = {enc(l, 2*c), enc(l, 2*c-1)};
    end
    e.v = (s >= cur_hoff) && (s < cur_hoff + w) && (l >= cur_voff) && (l < cur_voff + cur_vsize);
    if (!e.v) e.d = '0;
    e.c = (c >= CLAMP_POS) && (c < CLAMP_POS + CLAMP_LEN);
    e.g = (l >= GAIN_LINE) && (l < GAIN_LINE + GAIN_LEN);
    return e;
  endfunction

  task automatic step(input logic hs, input logic vs, input logic [47:0] px, input exp_t e);
    @(negedge clk);
    if (pipe1.chk) begin
      if (pix_valid_o) vcount++;
      if (pix_valid_o !== pipe1.v || pix_data_o !== pipe1.d) begin
        if (dat_err == 0) begin
          bad_act = longint'(pix_data_o);
          bad_exp = longint'(pipe1.d);
        end
        dat_err++;
      end
      if (clamp_o !== pipe1.c) clp_err++;
      if (gain_o !== pipe1.g) gn_err++;
    end
    pipe1 = pipe0;
    pipe0 = e;
    hsync_in = hs ^ cur_pol[0];
    vsync_in = vs ^ cur_pol[0];
    pix_in   = px;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 48'h0, '0);
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = a[3:0];
    reg_wdata = v[15:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic frame(input bit chk);
    logic [47:0] px;
    pipe0.chk = 1'b0;
    pipe1.chk = 1'b0;
    chk_on  = chk;
    dat_err = 0; clp_err = 0; gn_err = 0; vcount = 0;
    for (int l = 0; l < LINES; l++) begin
      for (int c = 0; c < LINE_CLKS; c++) begin
        if (cur_dual == 0) px = {24'hABCDEF, enc(l, c)};
        else               px = {enc(l, 2*c+1), enc(l, 2*c)};
        step(c < HS_LEN, l < VS_LINES, px, model(l, c));
      end
    end
    for (int t = 0; t < 2; t++) step(1'b0, 1'b0, 48'h0, model(LINES-1, LINE_CLKS+t));
    chk_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    string tags [NV] = '{"R1 R2 R3 R4 single mode window",
                         "R5 R4 single full-line window",
                         "R5 R8 dual even offset inverted syncs",
                         "R6 R8 dual odd offset inverted syncs",
                         "R6 R4 dual odd offset on last line"};
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_in = '0; hsync_in = 1'b0; vsync_in = 1'b0;
    pipe0 = '0; pipe1 = '0; chk_on = 1'b0;
    cur_dual = 0; cur_pol = 0; cur_hoff = 0; cur_voff = 0; cur_hhalf = 0; cur_vsize = 0;
    repeat (4) @(negedge clk);
    // R11: outputs held at zero during reset
    check(pix_valid_o == 0 && pix_data_o == 0 && clamp_o == 0 && gain_o == 0,
          "R11 reset outputs", longint'(pix_data_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({hs_present_o, hs_active_low_o, vs_present_o, vs_active_low_o, pix_valid_o} == 0,
          "R11 after reset flags",
          longint'({hs_present_o, hs_active_low_o, vs_present_o, vs_active_low_o, pix_valid_o}), 0);

    // R12: register map setup
    wr(5, 100);
    wr(6, 1000);
    wr(7, CLAMP_POS);
    wr(8, CLAMP_LEN);
    wr(9, GAIN_LINE);
    wr(10, GAIN_LEN);

    for (int i = 0; i < NV; i++) begin
      cur_dual  = VEC[i][0];
      cur_pol   = VEC[i][1];
      cur_hoff  = VEC[i][2];
      cur_voff  = VEC[i][3];
      cur_hhalf = VEC[i][4];
      cur_vsize = VEC[i][5];
      idle(4);
      wr(0, cur_dual);
      wr(1, cur_hoff);
      wr(2, cur_voff);
      wr(3, cur_hhalf);
      wr(4, cur_vsize);
      frame(1'b0);
      frame(1'b0);
      frame(1'b1);
      check(dat_err == 0, {tags[i], " data stream"}, bad_act, bad_exp);
      check(vcount == VEC[i][6], {tags[i], " word count"}, vcount, VEC[i][6]);
      check(clp_err == 0, "R9 clamp strobe timing", clp_err, 0);
      check(gn_err == 0, "R10 gain strobe timing", gn_err, 0);
      check(hs_present_o && vs_present_o, "R7 both syncs present",
            longint'({hs_present_o, vs_present_o}), 3);
      check(hs_active_low_o == cur_pol[0] && vs_active_low_o == cur_pol[0], "R8 polarity flags",
            longint'({hs_active_low_o, vs_active_low_o}), longint'({cur_pol[0], cur_pol[0]}));
    end

    // R7: horizontal sync stops; it times out first, vertical later
    idle(150);
    check(!hs_present_o && vs_present_o, "R7 horizontal timeout only",
          longint'({hs_present_o, vs_present_o}), 1);
    check(!pix_valid_o, "R4 nothing emitted without syncs", pix_valid_o, 0);
    idle(600);
    check(!hs_present_o && !vs_present_o, "R7 vertical timeout",
          longint'({hs_present_o, vs_present_o}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule